// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit sits between a 32-bit datapath and a word-wide, byte-addressed data memory in which each word holds four bytes and successive word addresses step by four. For a store it takes the register value, copies the byte or halfword across every lane of the bus and raises one write enable per byte lane, so that only the addressed bytes of the memory word change. For a load it takes the word that the memory returned, picks out the addressed byte or halfword and widens it to 32 bits with sign or zero fill.

The low two address bits give the byte offset inside the word. An input chooses the byte numbering: with little-endian numbering offset 0 is the least significant byte of the word, with big-endian numbering it is the most significant one. The word address is identical under both numberings. Accesses that do not sit on their natural boundary are flagged and never written. The address adder, the memory array and any cache lie outside the block. Every result is registered, so it appears one clock after the request.

Top module: `lsu_lane_align`

## Requirements
- R1: While rst_n is low and after its release until the first request, rsp_valid_o, misaligned_o, wr_be_o, wr_data_o and load_data_o are all zero.
- R2: Every output reflects the request sampled at the previous rising clock edge; rsp_valid_o equals req_valid_i from that edge.
- R3: With big_endian_i=0 byte offset k maps to lane k (bits 8k+7..8k); with big_endian_i=1 it maps to lane 3-k. A multi-byte value places its first-addressed byte at its most significant end for big-endian and at its least significant end for little-endian.
- R4: Size codes are 2'b00 byte, 2'b01 halfword, 2'b10 word, and 2'b11 acts as word. An aligned valid store (req_store_i=1) drives wr_be_o with one bit set for a byte, two adjacent bits (3:2 or 1:0) for a halfword and 4'b1111 for a word, at the lanes given by R3.
- R5: For every valid request wr_data_o carries store_data_i replicated: the low byte in all four lanes for a byte, the low halfword in both halves for a halfword, the whole word otherwise; with no valid request it is zero.
- R6: A signed load (req_unsigned_i=0) of a byte or halfword sign-extends the selected value to 32 bits.
- R7: An unsigned load (req_unsigned_i=1) of a byte or halfword zero-extends the selected value; a word load returns the assembled 32-bit value unchanged.
- R8: A halfword request with byte_off_i[0]=1, or a word request with byte_off_i nonzero, sets misaligned_o and forces wr_be_o and load_data_o to zero.
- R9: Loads and cycles without a valid request leave wr_be_o at zero; stores and cycles without a valid request leave load_data_o at zero.
- R10: After the word 0x23456789 is held in memory, a signed byte load at offset 1 returns 0x00000045 with big-endian numbering and 0x00000067 with little-endian numbering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | A request is present this cycle |
| req_store_i | input | 1 | 1 store, 0 load |
| req_size_i | input | 2 | Access width code (see R4) |
| req_unsigned_i | input | 1 | Zero-extend sub-word loads |
| big_endian_i | input | 1 | 1 selects big-endian byte numbering |
| byte_off_i | input | 2 | Address bits 1..0 |
| store_data_i | input | 32 | Register value to store |
| load_word_i | input | 32 | Word returned by the memory for a load |
| rsp_valid_o | output | 1 | Registered copy of req_valid_i |
| misaligned_o | output | 1 | Request was not naturally aligned |
| wr_be_o | output | 4 | Per-lane write enables |
| wr_data_o | output | 32 | Lane-replicated store data |
| load_data_o | output | 32 | Extended load result |

## Verification
Every result of this block, enables, store data, load value, misaligned flag and response valid, is due exactly one rising edge after the request is presented. The bench drives each request on a falling edge, waits for the next rising edge and samples one time unit after it, so each comparison reads the registered answer to that single request and the next request is not applied until the comparison is done. A reference built from per-offset byte addressing predicts the lanes and values independently of the mask-based logic, over random widths, offsets, numberings and data as well as the directed corners.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic        vld;
        logic        mis;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] rdata;
    } align_state_t;

endpackage

// File: rtl/lsu_lane_select.sv
module lsu_lane_select
    import lsu_align_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [$clog2(DATA_W/8)-1:0]          off_i,
    input  acc_size_e                            size_i,
    input  logic                                 big_i,
    output logic [$clog2(DATA_W/8)-1:0]          byte_lane_o,
    output logic [$clog2(DATA_W/8)-2:0]          half_pair_o,
    output logic                                 mis_o
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);
    localparam logic [OFF_W-1:0] LAST = OFF_W'(LANES - 1);

    logic [OFF_W-1:0] half_first;

    always_comb begin
        byte_lane_o = big_i ? (LAST - off_i) : off_i;
        half_first  = big_i ? (LAST - off_i - OFF_W'(1)) : off_i;
        half_pair_o = half_first[OFF_W-1:1];
        unique case (size_i)
            SZ_BYTE: mis_o = 1'b0;
            SZ_HALF: mis_o = off_i[0];
            default: mis_o = (off_i != '0);
        endcase
    end
endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
    import lsu_align_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  acc_size_e                        size_i,
    input  logic [$clog2(DATA_W/8)-1:0]      byte_lane_i,
    input  logic [$clog2(DATA_W/8)-2:0]      half_pair_i,
    input  logic                             en_i,
    input  logic [DATA_W-1:0]                data_i,
    output logic [DATA_W/8-1:0]              be_o,
    output logic [DATA_W-1:0]                data_o
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_ID = OFF_W'(k);
        localparam logic [OFF_W-2:0] PAIR_ID = LANE_ID[OFF_W-1:1];
        logic hit;
        always_comb begin
            unique case (size_i)
                SZ_BYTE: hit = (byte_lane_i == LANE_ID);
                SZ_HALF: hit = (half_pair_i == PAIR_ID);
                default: hit = 1'b1;
            endcase
            be_o[k] = en_i & hit;
            unique case (size_i)
                SZ_BYTE: data_o[8*k +: 8] = data_i[7:0];
                SZ_HALF: data_o[8*k +: 8] = data_i[8*(k%2) +: 8];
                default: data_o[8*k +: 8] = data_i[8*k +: 8];
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_align_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  acc_size_e                        size_i,
    input  logic                             unsigned_i,
    input  logic [$clog2(DATA_W/8)-1:0]      byte_lane_i,
    input  logic [$clog2(DATA_W/8)-2:0]      half_pair_i,
    input  logic                             en_i,
    input  logic [DATA_W-1:0]                word_i,
    output logic [DATA_W-1:0]                data_o
);
    logic [DATA_W-1:0] byte_sh;
    logic [DATA_W-1:0] half_sh;
    logic [7:0]        pick_b;
    logic [15:0]       pick_h;

    always_comb begin
        byte_sh = word_i >> (8 * byte_lane_i);
        half_sh = word_i >> (16 * half_pair_i);
        pick_b  = byte_sh[7:0];
        pick_h  = half_sh[15:0];
        unique case (size_i)
            SZ_BYTE: data_o = {{(DATA_W-8){~unsigned_i & pick_b[7]}}, pick_b};
            SZ_HALF: data_o = {{(DATA_W-16){~unsigned_i & pick_h[15]}}, pick_h};
            default: data_o = word_i;
        endcase
        if (!en_i) begin
            data_o = '0;
        end
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_align_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid_i,
    input  logic                   req_store_i,
    input  logic [1:0]             req_size_i,
    input  logic                   req_unsigned_i,
    input  logic                   big_endian_i,
    input  logic [1:0]             byte_off_i,
    input  logic [DATA_W-1:0]      store_data_i,
    input  logic [DATA_W-1:0]      load_word_i,
    output logic                   rsp_valid_o,
    output logic                   misaligned_o,
    output logic [DATA_W/8-1:0]    wr_be_o,
    output logic [DATA_W-1:0]      wr_data_o,
    output logic [DATA_W-1:0]      load_data_o
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);

    acc_size_e          size;
    logic [OFF_W-1:0]   byte_lane;
    logic [OFF_W-2:0]   half_pair;
    logic               mis;
    logic               st_en;
    logic               ld_en;
    logic [LANES-1:0]   pack_be;
    logic [DATA_W-1:0]  pack_data;
    logic [DATA_W-1:0]  ext_data;
    align_state_t       st_d;
    align_state_t       st_q;

    assign size  = acc_size_e'(req_size_i);
    assign st_en = req_valid_i & req_store_i & ~mis;
    assign ld_en = req_valid_i & ~req_store_i & ~mis;

    lsu_lane_select #(.DATA_W(DATA_W)) u_sel (
        .off_i       (byte_off_i),
        .size_i      (size),
        .big_i       (big_endian_i),
        .byte_lane_o (byte_lane),
        .half_pair_o (half_pair),
        .mis_o       (mis)
    );

    lsu_store_pack #(.DATA_W(DATA_W)) u_pack (
        .size_i      (size),
        .byte_lane_i (byte_lane),
        .half_pair_i (half_pair),
        .en_i        (st_en),
        .data_i      (store_data_i),
        .be_o        (pack_be),
        .data_o      (pack_data)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_ext (
        .size_i      (size),
        .unsigned_i  (req_unsigned_i),
        .byte_lane_i (byte_lane),
        .half_pair_i (half_pair),
        .en_i        (ld_en),
        .word_i      (load_word_i),
        .data_o      (ext_data)
    );

    always_comb begin
        st_d       = '0;
        st_d.vld   = req_valid_i;
        st_d.mis   = req_valid_i & mis;
        st_d.be    = pack_be;
        st_d.wdata = req_valid_i ? pack_data : '0;
        st_d.rdata = ext_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o  = st_q.vld;
    assign misaligned_o = st_q.mis;
    assign wr_be_o      = st_q.be;
    assign wr_data_o    = st_q.wdata;
    assign load_data_o  = st_q.rdata;

    a_r4_byte_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_store_i && req_size_i == 2'b00) |=> ($countones(wr_be_o) == 1));

    a_r4_half_twohot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_store_i && req_size_i == 2'b01 && !byte_off_i[0])
        |=> (wr_be_o == 4'b0011 || wr_be_o == 4'b1100));

    a_r8_misaligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_size_i != 2'b00 && byte_off_i != 2'b00
         && !(req_size_i == 2'b01 && !byte_off_i[0]))
        |=> (misaligned_o && wr_be_o == '0 && load_data_o == '0));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_valid_o && wr_be_o == '0 && load_data_o == '0));

    a_r7_unsigned_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_store_i && req_unsigned_i && req_size_i == 2'b00)
        |=> (load_data_o[DATA_W-1:8] == '0));

    a_r6_signed_byte_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_store_i && !req_unsigned_i && req_size_i == 2'b00)
        |=> (load_data_o[DATA_W-1:7] == '0 || load_data_o[DATA_W-1:7] == '1));

endmodule

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_store_i = 1'b0;
    logic [1:0]  req_size_i = 2'b00;
    logic        req_unsigned_i = 1'b0;
    logic        big_endian_i = 1'b0;
    logic [1:0]  byte_off_i = 2'b00;
    logic [31:0] store_data_i = '0;
    logic [31:0] load_word_i = '0;
    logic        rsp_valid_o;
    logic        misaligned_o;
    logic [3:0]  wr_be_o;
    logic [31:0] wr_data_o;
    logic [31:0] load_data_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lsu_lane_align dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_store_i(req_store_i),
        .req_size_i(req_size_i), .req_unsigned_i(req_unsigned_i), .big_endian_i(big_endian_i),
        .byte_off_i(byte_off_i), .store_data_i(store_data_i), .load_word_i(load_word_i),
        .rsp_valid_o(rsp_valid_o), .misaligned_o(misaligned_o), .wr_be_o(wr_be_o),
        .wr_data_o(wr_data_o), .load_data_o(load_data_o)
    );

    function automatic int nbytes(logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    function automatic int lane_of(int k, logic big);
        return big ? 3 - k : k;
    endfunction

    function automatic logic exp_mis(logic [1:0] sz, logic [1:0] off);
        int n = nbytes(sz);
        return (n == 2 && off[0]) || (n == 4 && off != 2'b00);
    endfunction

    function automatic logic [3:0] exp_be(logic v, logic st, logic [1:0] sz, logic [1:0] off, logic big);
        logic [3:0] m = '0;
        if (v && st && !exp_mis(sz, off))
            for (int i = 0; i < nbytes(sz); i++) m[lane_of(int'(off) + i, big)] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] exp_wd(logic v, logic [1:0] sz, logic [31:0] d);
        if (!v) return '0;
        if (nbytes(sz) == 1) return {4{d[7:0]}};
        if (nbytes(sz) == 2) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] exp_ld(logic v, logic st, logic [1:0] sz, logic uns,
                                           logic [1:0] off, logic big, logic [31:0] w);
        logic [31:0] r = '0;
        logic [7:0]  b;
        int n = nbytes(sz);
        if (!v || st || exp_mis(sz, off)) return '0;
        for (int i = 0; i < n; i++) begin
            b = w[8*lane_of(int'(off) + i, big) +: 8];
            if (big) r = (r << 8) | {24'h0, b};
            else     r = r | ({24'h0, b} << (8*i));
        end
        if (!uns && n == 1 && r[7])  r[31:8]  = '1;
        if (!uns && n == 2 && r[15]) r[31:16] = '1;
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic apply(logic v, logic st, logic [1:0] sz, logic uns, logic [1:0] off,
                         logic big, logic [31:0] sd, logic [31:0] lw);
        @(negedge clk);
        req_valid_i = v; req_store_i = st; req_size_i = sz; req_unsigned_i = uns;
        byte_off_i = off; big_endian_i = big; store_data_i = sd; load_word_i = lw;
        @(posedge clk);
        #1;
    endtask

    task automatic run_full(logic v, logic st, logic [1:0] sz, logic uns, logic [1:0] off,
                            logic big, logic [31:0] sd, logic [31:0] lw);
        apply(v, st, sz, uns, off, big, sd, lw);
        check("R2 rsp_valid", {31'h0, rsp_valid_o}, {31'h0, v});
        check("R8 misaligned", {31'h0, misaligned_o}, {31'h0, v && exp_mis(sz, off)});
        check("R4 wr_be", {28'h0, wr_be_o}, {28'h0, exp_be(v, st, sz, off, big)});
        check("R5 wr_data", wr_data_o, exp_wd(v, sz, sd));
        check(uns ? "R7 load_data" : "R6 load_data", load_data_o,
              exp_ld(v, st, sz, uns, off, big, lw));
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1a7e));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", {31'h0, rsp_valid_o}, 32'h0);
        check("R1 reset be", {28'h0, wr_be_o}, 32'h0);
        check("R1 reset data", wr_data_o | load_data_o, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", {31'h0, rsp_valid_o | misaligned_o}, 32'h0);

        // R10: byte at offset 1 of 0x23456789
        apply(1, 0, 2'b00, 0, 2'd1, 1, 32'h0, 32'h23456789);
        check("R10 big-endian byte", load_data_o, 32'h00000045);
        apply(1, 0, 2'b00, 0, 2'd1, 0, 32'h0, 32'h23456789);
        check("R10 little-endian byte", load_data_o, 32'h00000067);

        // R3: offset 0 lane under both numberings
        apply(1, 1, 2'b00, 0, 2'd0, 0, 32'hAB, 32'h0);
        check("R3 LE offset0 lane", {28'h0, wr_be_o}, 32'h1);
        apply(1, 1, 2'b00, 0, 2'd0, 1, 32'hAB, 32'h0);
        check("R3 BE offset0 lane", {28'h0, wr_be_o}, 32'h8);
        apply(1, 0, 2'b01, 1, 2'd0, 1, 32'h0, 32'h1234ABCD);
        check("R3 BE half offset0", load_data_o, 32'h00001234);
        apply(1, 0, 2'b01, 1, 2'd0, 0, 32'h0, 32'h1234ABCD);
        check("R7 LE half unsigned", load_data_o, 32'h0000ABCD);
        apply(1, 0, 2'b01, 0, 2'd0, 0, 32'h0, 32'h1234ABCD);
        check("R6 LE half signed", load_data_o, 32'hFFFFABCD);
        apply(1, 0, 2'b00, 0, 2'd3, 0, 32'h0, 32'h80000000);
        check("R6 byte sign", load_data_o, 32'hFFFFFF80);

        // R4: word store, size code 11 acts as word
        apply(1, 1, 2'b11, 0, 2'd0, 0, 32'hCAFEF00D, 32'h0);
        check("R4 code11 word be", {28'h0, wr_be_o}, 32'hF);
        check("R5 word data", wr_data_o, 32'hCAFEF00D);

        // R8: misaligned cases
        apply(1, 1, 2'b01, 0, 2'd1, 0, 32'h1111, 32'h0);
        check("R8 half odd flag", {31'h0, misaligned_o}, 32'h1);
        check("R8 half odd be", {28'h0, wr_be_o}, 32'h0);
        apply(1, 0, 2'b10, 0, 2'd2, 1, 32'h0, 32'hFFFFFFFF);
        check("R8 word off2 load", load_data_o, 32'h0);

        // R9: idle and cross-direction quietness
        apply(0, 1, 2'b10, 0, 2'd0, 0, 32'h12345678, 32'h0);
        check("R9 idle be", {28'h0, wr_be_o}, 32'h0);
        check("R9 idle valid", {31'h0, rsp_valid_o}, 32'h0);
        apply(1, 0, 2'b10, 0, 2'd0, 0, 32'h12345678, 32'h9);
        check("R9 load no be", {28'h0, wr_be_o}, 32'h0);
        apply(1, 1, 2'b10, 0, 2'd0, 0, 32'h1, 32'hFFFFFFFF);
        check("R9 store no load", load_data_o, 32'h0);

        for (int it = 0; it < 400; it++) begin
            run_full(($urandom % 8) != 0, $urandom % 2, 2'($urandom % 4), $urandom % 2,
                     2'($urandom % 4), $urandom % 2, $urandom, $urandom);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule